// File: doc/BRIEF.md
# Early Partial-Tag Cache Bank Lookup Front End

This block sits in front of an 8-way set-associative cache bank and lets the bank begin an access before the whole address has arrived. A short early message, sent over a fast narrow link, carries a transaction ID and the set index. In aggressive mode it also carries the 8 lowest tag bits. On acceptance the bank reads the tags and data of that set at once. In aggressive mode it keeps as candidates only the valid ways whose low tag byte equals the partial tag. In plain mode every valid way is a candidate. The ID, the set, the mode, the candidate mask and the row that was read are parked in one of a small number of pending slots.

The complete address follows later over the slower, wider path. It finds its pending slot by transaction ID. If the slot holds the same set, the full tag is compared against the parked candidates only, and this either confirms a hit or cancels it. If a candidate survived the partial compare but no full tag matches, the access is a false match. The speculative data is dropped, a miss is reported, and a one-cycle false-match pulse is raised for external statistics. A full address that has no pending slot, or whose slot holds a different set, is served as an ordinary lookup of the current array, and any such slot is freed. A behavioural fill port writes tag, data and valid into one way of one set.

The early path is valid/ready. A message transfers on a clock edge where `early_valid` and `early_ready` are both high. The sender must hold the message stable while `early_ready` is low. `early_ready` is low exactly when every pending slot is occupied, and it rises again in the cycle after a full address frees a slot. The full-address path and the response path carry no back-pressure. Each full address is accepted on the edge where `full_valid` is high and is answered by a response one clock later.

Top module: `ept_bank_front`

## Requirements
- R1: After synchronous reset, `early_ready` is 1, `resp_valid` is 0 and `false_match` is 0, and no pending slot or array way is valid.
- R2: At most SLOTS (4) early messages are pending. With all slots occupied, `early_ready` is 0 and a message offered then is not captured. A later full address with that ID is then served as an ordinary lookup (`resp_early`=0). `early_ready` returns to 1 in the cycle after a full address frees a slot.
- R3: A full address accepted on edge N yields `resp_valid`=1 for exactly one cycle after edge N, with `resp_id` equal to its ID. When a pending slot with that ID and the same set exists, `resp_early`=1 and the slot is freed.
- R4: In aggressive mode (`early_aggr`=1), candidates are the valid ways whose tag bits [7:0] equal `early_ptag`. A candidate whose full 16-bit tag equals `full_tag` gives `resp_hit`=1, `resp_way` set to that way number, and `resp_data` set to its data.
- R5: In aggressive mode, a full address with at least one candidate but no full-tag match gives `resp_hit`=0, `resp_data`=0, and `false_match`=1 in the same cycle as `resp_valid`. With no candidate at all, `false_match` stays 0.
- R6: In plain mode (`early_aggr`=0), all valid ways of the set are compared with the full tag. A miss then never raises `false_match`. Any miss reports `resp_way`=0 and `resp_data`=0.
- R7: A full address with no pending slot of that ID looks up the current array at `full_set` over all valid ways and reports `resp_early`=0. A fill (`fill_valid`=1) writes tag, data and valid into way `fill_way` of set `fill_set` at the clock edge.
- R8: When several ways pass the partial compare, all of them stay candidates, and the full tag picks the one that hits.
- R9: An early-path response returns the tag and data read when the early message was accepted. A fill made to that set while the slot is pending does not change that response.
- R10: A full address whose pending slot holds a different set is served as an ordinary lookup at `full_set` with `resp_early`=0, and the slot is freed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| early_valid | input | 1 | Early message offered |
| early_ready | output | 1 | A pending slot is free |
| early_id | input | ID_W (3) | Transaction ID of the early message |
| early_set | input | SET_W (4) | Set index sent ahead |
| early_ptag | input | PTAG_W (8) | Low tag bits, used in aggressive mode |
| early_aggr | input | 1 | 1 = aggressive (partial tag valid), 0 = plain |
| full_valid | input | 1 | Full address present this cycle |
| full_id | input | ID_W (3) | Transaction ID of the full address |
| full_set | input | SET_W (4) | Set index of the full address |
| full_tag | input | TAG_W (16) | Complete tag |
| fill_valid | input | 1 | Write one array way |
| fill_set | input | SET_W (4) | Set written by the fill |
| fill_way | input | 3 | Way written by the fill |
| fill_tag | input | TAG_W (16) | Tag written by the fill |
| fill_data | input | DATA_W (32) | Data written by the fill |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_id | output | ID_W (3) | ID of the answered full address |
| resp_early | output | 1 | 1 = served from a pending early slot |
| resp_hit | output | 1 | Confirmed hit |
| resp_way | output | 3 | Hitting way, 0 on miss |
| resp_data | output | DATA_W (32) | Data of the hitting way, 0 on miss |
| false_match | output | 1 | Partial-tag candidate cancelled by the full tag |

## Verification
One set is filled so that two ways share a low tag byte and a third way has a different one. Aggressive lookups whose partial tag selects a single way, two ways, or no way then separate true hits, choice between several candidates, false matches and plain misses. The same full tags sent after plain-mode early messages and with no early message at all show whether the candidate filter was applied, and whether the ordinary path is taken when it should be. Filling the slots to capacity, and refilling a set while a lookup is pending, show that a stalled message is never captured and that early responses use the row read at acceptance. A full address whose set differs from its slot's shows that the slot is released.

// File: rtl/ept_pkg.sv
package ept_pkg;

  // Source of a lookup resolved in the current cycle.
  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_PLAIN = 2'd1,
    LK_EARLY = 2'd2
  } lk_src_e;

  // Index of the lowest set bit of a mask of up to 32 bits; 0 when empty.
  function automatic logic [4:0] low_index(input logic [31:0] m);
    logic [4:0] r;
    r = '0;
    for (int i = 31; i >= 0; i--) begin
      if (m[i]) r = i[4:0];
    end
    return r;
  endfunction

endpackage

// File: rtl/ept_tag_store.sv
module ept_tag_store #(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 16,
  parameter int WAYS   = 8,
  parameter int DATA_W = 32,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fill_en,
  input  logic [SET_W-1:0]             fill_set,
  input  logic [WAY_W-1:0]             fill_way,
  input  logic [TAG_W-1:0]             fill_tag,
  input  logic [DATA_W-1:0]            fill_data,
  input  logic [SET_W-1:0]             rd_a_set,
  output logic [WAYS-1:0]              rd_a_vld,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_a_tags,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_a_data,
  input  logic [SET_W-1:0]             rd_b_set,
  output logic [WAYS-1:0]              rd_b_vld,
  output logic [WAYS-1:0][TAG_W-1:0]   rd_b_tags,
  output logic [WAYS-1:0][DATA_W-1:0]  rd_b_data
);

  logic [WAYS-1:0]             vld_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q  [SETS];
  logic [WAYS-1:0][DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (fill_en) begin
      vld_q[fill_set][fill_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set][fill_way]  <= fill_tag;
      data_q[fill_set][fill_way] <= fill_data;
    end
  end

  assign rd_a_vld  = vld_q[rd_a_set];
  assign rd_a_tags = tag_q[rd_a_set];
  assign rd_a_data = data_q[rd_a_set];
  assign rd_b_vld  = vld_q[rd_b_set];
  assign rd_b_tags = tag_q[rd_b_set];
  assign rd_b_data = data_q[rd_b_set];

endmodule

// File: rtl/ept_part_filter.sv
module ept_part_filter #(
  parameter int WAYS   = 8,
  parameter int PTAG_W = 8
) (
  input  logic [WAYS-1:0]              way_vld,
  input  logic [WAYS-1:0][PTAG_W-1:0]  way_ptags,
  input  logic [PTAG_W-1:0]            ptag,
  input  logic                         aggr,
  output logic [WAYS-1:0]              cand
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic low_eq;
    assign low_eq  = (way_ptags[w] == ptag);
    assign cand[w] = way_vld[w] & (~aggr | low_eq);
  end

endmodule

// File: rtl/ept_resolve.sv
module ept_resolve
  import ept_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int WAYS   = 8,
  parameter int DATA_W = 32,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]              cand,
  input  logic [WAYS-1:0][TAG_W-1:0]   tags,
  input  logic [WAYS-1:0][DATA_W-1:0]  data,
  input  logic [TAG_W-1:0]             full_tag,
  output logic                         hit,
  output logic [WAY_W-1:0]             hit_way,
  output logic [DATA_W-1:0]            hit_data
);

  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = cand[w] & (tags[w] == full_tag);
  end

  always_comb begin
    hit      = |match;
    hit_way  = '0;
    hit_data = '0;
    if (hit) begin
      hit_way  = WAY_W'(low_index(32'(match)));
      hit_data = data[hit_way];
    end
  end

endmodule

// File: rtl/ept_pend_table.sv
module ept_pend_table
  import ept_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 16,
  parameter int WAYS   = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int SLOTS  = 4,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                         clk,
  input  logic                         rst,
  output logic                         not_full,
  input  logic                         alloc_en,
  input  logic [ID_W-1:0]              alloc_id,
  input  logic [SET_W-1:0]             alloc_set,
  input  logic                         alloc_aggr,
  input  logic [WAYS-1:0]              alloc_cand,
  input  logic [WAYS-1:0][TAG_W-1:0]   alloc_tags,
  input  logic [WAYS-1:0][DATA_W-1:0]  alloc_data,
  input  logic [ID_W-1:0]              search_id,
  output logic                         found,
  output logic [SLOT_W-1:0]            found_slot,
  output logic [SET_W-1:0]             found_set,
  output logic                         found_aggr,
  output logic [WAYS-1:0]              found_cand,
  output logic [WAYS-1:0][TAG_W-1:0]   found_tags,
  output logic [WAYS-1:0][DATA_W-1:0]  found_data,
  input  logic                         free_en,
  input  logic [SLOT_W-1:0]            free_slot
);

  logic [SLOTS-1:0]            vld_q;
  logic [ID_W-1:0]             id_q   [SLOTS];
  logic [SET_W-1:0]            set_q  [SLOTS];
  logic [SLOTS-1:0]            aggr_q;
  logic [WAYS-1:0]             cand_q [SLOTS];
  logic [WAYS-1:0][TAG_W-1:0]  tags_q [SLOTS];
  logic [WAYS-1:0][DATA_W-1:0] data_q [SLOTS];
  logic [SLOT_W-1:0]           alloc_slot;

  assign not_full   = ~&vld_q;
  assign alloc_slot = SLOT_W'(low_index(32'(~vld_q)));

  always_comb begin
    found      = 1'b0;
    found_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (vld_q[i] && id_q[i] == search_id) begin
        found      = 1'b1;
        found_slot = i[SLOT_W-1:0];
      end
    end
  end

  assign found_set  = set_q[found_slot];
  assign found_aggr = aggr_q[found_slot];
  assign found_cand = cand_q[found_slot];
  assign found_tags = tags_q[found_slot];
  assign found_data = data_q[found_slot];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (free_en)  vld_q[free_slot]  <= 1'b0;
      if (alloc_en) vld_q[alloc_slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      id_q[alloc_slot]   <= alloc_id;
      set_q[alloc_slot]  <= alloc_set;
      aggr_q[alloc_slot] <= alloc_aggr;
      cand_q[alloc_slot] <= alloc_cand;
      tags_q[alloc_slot] <= alloc_tags;
      data_q[alloc_slot] <= alloc_data;
    end
  end

endmodule

// File: rtl/ept_bank_front.sv
module ept_bank_front
  import ept_pkg::*;
#(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 16,
  parameter int PTAG_W = 8,
  parameter int WAYS   = 8,
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int SLOTS  = 4,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              early_valid,
  output logic              early_ready,
  input  logic [ID_W-1:0]   early_id,
  input  logic [SET_W-1:0]  early_set,
  input  logic [PTAG_W-1:0] early_ptag,
  input  logic              early_aggr,
  input  logic              full_valid,
  input  logic [ID_W-1:0]   full_id,
  input  logic [SET_W-1:0]  full_set,
  input  logic [TAG_W-1:0]  full_tag,
  input  logic              fill_valid,
  input  logic [SET_W-1:0]  fill_set,
  input  logic [WAY_W-1:0]  fill_way,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  output logic              resp_valid,
  output logic [ID_W-1:0]   resp_id,
  output logic              resp_early,
  output logic              resp_hit,
  output logic [WAY_W-1:0]  resp_way,
  output logic [DATA_W-1:0] resp_data,
  output logic              false_match
);

  // early side: row read at acceptance
  logic                        early_fire;
  logic [WAYS-1:0]             a_vld;
  logic [WAYS-1:0][TAG_W-1:0]  a_tags;
  logic [WAYS-1:0][DATA_W-1:0] a_data;
  logic [WAYS-1:0][PTAG_W-1:0] a_ptags;
  logic [WAYS-1:0]             a_cand;

  // full side: ordinary row read
  logic [WAYS-1:0]             b_vld;
  logic [WAYS-1:0][TAG_W-1:0]  b_tags;
  logic [WAYS-1:0][DATA_W-1:0] b_data;

  // pending slot matched by the full address
  logic                        p_found;
  logic [SLOT_W-1:0]           p_slot;
  logic [SET_W-1:0]            p_set;
  logic                        p_aggr;
  logic [WAYS-1:0]             p_cand;
  logic [WAYS-1:0][TAG_W-1:0]  p_tags;
  logic [WAYS-1:0][DATA_W-1:0] p_data;
  logic                        slot_free;

  // resolution
  lk_src_e                     lk_src;
  logic [WAYS-1:0]             sel_cand;
  logic [WAYS-1:0][TAG_W-1:0]  sel_tags;
  logic [WAYS-1:0][DATA_W-1:0] sel_data;
  logic                        r_hit;
  logic [WAY_W-1:0]            r_way;
  logic [DATA_W-1:0]           r_data;
  logic                        fm_next;

  assign early_fire = early_valid & early_ready;

  ept_tag_store #(
    .SET_W (SET_W),
    .TAG_W (TAG_W),
    .WAYS  (WAYS),
    .DATA_W(DATA_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .fill_en  (fill_valid),
    .fill_set (fill_set),
    .fill_way (fill_way),
    .fill_tag (fill_tag),
    .fill_data(fill_data),
    .rd_a_set (early_set),
    .rd_a_vld (a_vld),
    .rd_a_tags(a_tags),
    .rd_a_data(a_data),
    .rd_b_set (full_set),
    .rd_b_vld (b_vld),
    .rd_b_tags(b_tags),
    .rd_b_data(b_data)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_low
    assign a_ptags[w] = a_tags[w][PTAG_W-1:0];
  end

  ept_part_filter #(
    .WAYS  (WAYS),
    .PTAG_W(PTAG_W)
  ) u_filter (
    .way_vld  (a_vld),
    .way_ptags(a_ptags),
    .ptag     (early_ptag),
    .aggr     (early_aggr),
    .cand     (a_cand)
  );

  ept_pend_table #(
    .SET_W (SET_W),
    .TAG_W (TAG_W),
    .WAYS  (WAYS),
    .DATA_W(DATA_W),
    .ID_W  (ID_W),
    .SLOTS (SLOTS)
  ) u_pend (
    .clk       (clk),
    .rst       (rst),
    .not_full  (early_ready),
    .alloc_en  (early_fire),
    .alloc_id  (early_id),
    .alloc_set (early_set),
    .alloc_aggr(early_aggr),
    .alloc_cand(a_cand),
    .alloc_tags(a_tags),
    .alloc_data(a_data),
    .search_id (full_id),
    .found     (p_found),
    .found_slot(p_slot),
    .found_set (p_set),
    .found_aggr(p_aggr),
    .found_cand(p_cand),
    .found_tags(p_tags),
    .found_data(p_data),
    .free_en   (slot_free),
    .free_slot (p_slot)
  );

  // Any slot named by a full address is released, same set or not.
  assign slot_free = full_valid & p_found;

  always_comb begin
    if (!full_valid)                        lk_src = LK_IDLE;
    else if (p_found && p_set == full_set)  lk_src = LK_EARLY;
    else                                    lk_src = LK_PLAIN;
  end

  always_comb begin
    if (lk_src == LK_EARLY) begin
      sel_cand = p_cand;
      sel_tags = p_tags;
      sel_data = p_data;
    end else begin
      sel_cand = b_vld;
      sel_tags = b_tags;
      sel_data = b_data;
    end
  end

  ept_resolve #(
    .TAG_W (TAG_W),
    .WAYS  (WAYS),
    .DATA_W(DATA_W)
  ) u_resolve (
    .cand    (sel_cand),
    .tags    (sel_tags),
    .data    (sel_data),
    .full_tag(full_tag),
    .hit     (r_hit),
    .hit_way (r_way),
    .hit_data(r_data)
  );

  assign fm_next = (lk_src == LK_EARLY) & p_aggr & (|p_cand) & ~r_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid  <= 1'b0;
      resp_id     <= '0;
      resp_early  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_way    <= '0;
      resp_data   <= '0;
      false_match <= 1'b0;
    end else begin
      resp_valid  <= (lk_src != LK_IDLE);
      resp_id     <= full_id;
      resp_early  <= (lk_src == LK_EARLY);
      resp_hit    <= full_valid & r_hit;
      resp_way    <= r_way;
      resp_data   <= r_data;
      false_match <= fm_next;
    end
  end

endmodule

// File: rtl/ept_bank_front_chk.sv
module ept_bank_front_chk #(
  parameter int WAY_W  = 3,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              early_valid,
  input logic              early_ready,
  input logic              full_valid,
  input logic              resp_valid,
  input logic              resp_early,
  input logic              resp_hit,
  input logic [WAY_W-1:0]  resp_way,
  input logic [DATA_W-1:0] resp_data,
  input logic              false_match
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (early_valid && !early_ready && !full_valid) |=> !early_ready); // R2

  AST_RESP_FOLLOWS_FULL: assert property (@(posedge clk) disable iff (rst)
    full_valid |=> resp_valid); // R3

  AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
    !full_valid |=> (!resp_valid && !false_match)); // R3

  AST_FM_IS_EARLY_MISS: assert property (@(posedge clk) disable iff (rst)
    false_match |-> (resp_valid && resp_early && !resp_hit)); // R5

  AST_MISS_ZEROED: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_hit) |-> (resp_way == '0 && resp_data == '0)); // R6

endmodule

bind ept_bank_front ept_bank_front_chk #(
  .WAY_W (WAY_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .early_valid(early_valid),
  .early_ready(early_ready),
  .full_valid (full_valid),
  .resp_valid (resp_valid),
  .resp_early (resp_early),
  .resp_hit   (resp_hit),
  .resp_way   (resp_way),
  .resp_data  (resp_data),
  .false_match(false_match)
);

// File: tb/ept_bank_front_tb_top.sv
`timescale 1ns/1ps
module ept_bank_front_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        early_valid = 1'b0;
  logic        early_ready;
  logic [2:0]  early_id = '0;
  logic [3:0]  early_set = '0;
  logic [7:0]  early_ptag = '0;
  logic        early_aggr = 1'b0;
  logic        full_valid = 1'b0;
  logic [2:0]  full_id = '0;
  logic [3:0]  full_set = '0;
  logic [15:0] full_tag = '0;
  logic        fill_valid = 1'b0;
  logic [3:0]  fill_set = '0;
  logic [2:0]  fill_way = '0;
  logic [15:0] fill_tag = '0;
  logic [31:0] fill_data = '0;
  logic        resp_valid;
  logic [2:0]  resp_id;
  logic        resp_early;
  logic        resp_hit;
  logic [2:0]  resp_way;
  logic [31:0] resp_data;
  logic        false_match;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  ept_bank_front dut_i (
    .clk(clk), .rst(rst),
    .early_valid(early_valid), .early_ready(early_ready), .early_id(early_id),
    .early_set(early_set), .early_ptag(early_ptag), .early_aggr(early_aggr),
    .full_valid(full_valid), .full_id(full_id), .full_set(full_set), .full_tag(full_tag),
    .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
    .fill_tag(fill_tag), .fill_data(fill_data),
    .resp_valid(resp_valid), .resp_id(resp_id), .resp_early(resp_early),
    .resp_hit(resp_hit), .resp_way(resp_way), .resp_data(resp_data),
    .false_match(false_match)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] dval(input int s, input int w, input int gen);
    return 32'hC000_0000 | (gen << 16) | (s << 8) | w;
  endfunction

  task automatic do_fill(input int s, input int w, input logic [15:0] t, input logic [31:0] d);
    fill_valid = 1'b1; fill_set = 4'(s); fill_way = 3'(w); fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // Offers an early message for 'hold' cycles; returns ready seen in the first cycle.
  task automatic do_early(input int id, input int s, input logic [7:0] pt, input bit aggr,
                          input int hold, output bit rdy);
    early_valid = 1'b1; early_id = 3'(id); early_set = 4'(s);
    early_ptag = pt; early_aggr = aggr;
    rdy = early_ready;
    repeat (hold) @(negedge clk);
    early_valid = 1'b0;
  endtask

  task automatic do_full(input string req, input int id, input int s, input logic [15:0] t,
                         input bit x_early, input bit x_hit, input int x_way,
                         input logic [31:0] x_data, input bit x_fm);
    full_valid = 1'b1; full_id = 3'(id); full_set = 4'(s); full_tag = t;
    @(negedge clk);
    full_valid = 1'b0;
    check(req, "resp_valid", 64'(resp_valid), 64'd1);
    check(req, "resp_id", 64'(resp_id), 64'(id));
    check(req, "resp_early", 64'(resp_early), 64'(x_early));
    check(req, "resp_hit", 64'(resp_hit), 64'(x_hit));
    check(req, "resp_way", 64'(resp_way), 64'(x_way));
    check(req, "resp_data", 64'(resp_data), 64'(x_data));
    check(req, "false_match", 64'(false_match), 64'(x_fm));
  endtask

  task automatic t_reset();
    check("R1", "early_ready", 64'(early_ready), 64'd1);
    check("R1", "resp_valid", 64'(resp_valid), 64'd0);
    check("R1", "false_match", 64'(false_match), 64'd0);
    do_full("R1", 7, 3, 16'h1234, 1'b0, 1'b0, 0, 32'd0, 1'b0); // array empty
  endtask

  task automatic t_ordinary();
    do_fill(3, 1, 16'h1234, dval(3, 1, 0));
    do_fill(3, 5, 16'h5634, dval(3, 5, 0));
    do_fill(3, 2, 16'hABCD, dval(3, 2, 0));
    do_fill(4, 0, 16'hABCD, dval(4, 0, 0));
    do_full("R7", 6, 3, 16'hABCD, 1'b0, 1'b1, 2, dval(3, 2, 0), 1'b0);
    do_full("R7", 6, 3, 16'h9999, 1'b0, 1'b0, 0, 32'd0, 1'b0);
    @(negedge clk);
    check("R3", "resp_valid drops", 64'(resp_valid), 64'd0);
  endtask

  task automatic t_aggr_hit();
    bit r;
    do_early(1, 3, 8'hCD, 1'b1, 1, r);
    check("R2", "ready on free slot", 64'(r), 64'd1);
    do_full("R4", 1, 3, 16'hABCD, 1'b1, 1'b1, 2, dval(3, 2, 0), 1'b0);
  endtask

  task automatic t_multi_cand();
    bit r;
    do_early(2, 3, 8'h34, 1'b1, 1, r);
    do_full("R8", 2, 3, 16'h5634, 1'b1, 1'b1, 5, dval(3, 5, 0), 1'b0);
    do_early(2, 3, 8'h34, 1'b1, 1, r);
    do_full("R8", 2, 3, 16'h1234, 1'b1, 1'b1, 1, dval(3, 1, 0), 1'b0);
  endtask

  task automatic t_false_match();
    bit r;
    do_early(3, 3, 8'h34, 1'b1, 1, r);
    do_full("R5", 3, 3, 16'h7734, 1'b1, 1'b0, 0, 32'd0, 1'b1);
    @(negedge clk);
    check("R5", "false_match one cycle", 64'(false_match), 64'd0);
    do_early(3, 3, 8'hEE, 1'b1, 1, r);   // no candidate at all
    do_full("R5", 3, 3, 16'h11EE, 1'b1, 1'b0, 0, 32'd0, 1'b0);
  endtask

  task automatic t_plain();
    bit r;
    do_early(4, 3, 8'h00, 1'b0, 1, r);
    do_full("R6", 4, 3, 16'h7734, 1'b1, 1'b0, 0, 32'd0, 1'b0);
    do_early(4, 3, 8'h00, 1'b0, 1, r);   // partial tag ignored in plain mode
    do_full("R6", 4, 3, 16'hABCD, 1'b1, 1'b1, 2, dval(3, 2, 0), 1'b0);
  endtask

  task automatic t_backpressure();
    bit r;
    for (int i = 0; i < 4; i++) begin
      do_early(i, 3, 8'hCD, 1'b1, 1, r);
      check("R2", "ready below capacity", 64'(r), 64'd1);
    end
    do_early(4, 3, 8'hCD, 1'b1, 2, r);
    check("R2", "ready when full", 64'(r), 64'd0);
    check("R2", "ready still low", 64'(early_ready), 64'd0);
    do_full("R3", 0, 3, 16'hABCD, 1'b1, 1'b1, 2, dval(3, 2, 0), 1'b0);
    check("R2", "ready after free", 64'(early_ready), 64'd1);
    do_full("R2", 4, 3, 16'hABCD, 1'b0, 1'b1, 2, dval(3, 2, 0), 1'b0); // stalled msg not taken
    for (int i = 1; i < 4; i++)
      do_full("R3", i, 3, 16'hABCD, 1'b1, 1'b1, 2, dval(3, 2, 0), 1'b0);
  endtask

  task automatic t_set_mismatch();
    bit r;
    do_early(6, 3, 8'hCD, 1'b1, 1, r);
    do_full("R10", 6, 4, 16'hABCD, 1'b0, 1'b1, 0, dval(4, 0, 0), 1'b0);
    do_full("R10", 6, 3, 16'hABCD, 1'b0, 1'b1, 2, dval(3, 2, 0), 1'b0); // slot gone
  endtask

  task automatic t_snapshot();
    bit r;
    do_early(5, 3, 8'hCD, 1'b1, 1, r);
    do_fill(3, 2, 16'hABCD, dval(3, 2, 1));
    do_full("R9", 5, 3, 16'hABCD, 1'b1, 1'b1, 2, dval(3, 2, 0), 1'b0);
    do_full("R7", 7, 3, 16'hABCD, 1'b0, 1'b1, 2, dval(3, 2, 1), 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ordinary();
    t_aggr_hit();
    t_multi_cand();
    t_false_match();
    t_plain();
    t_backpressure();
    t_set_mismatch();
    t_snapshot();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule